// File: doc/BRIEF.md
# Automatic Serial Block-Transfer Controller

This block is a slave-side serial engine that exchanges a programmed number of bytes between a small on-chip RAM buffer and an 8-bit shift register without processor help. Software writes a start address and a byte count together with a start command. From then on the controller works through the bytes on its own. For each byte it reads a byte from RAM into the shift register. An external master then clocks eight bits out and eight bits in. The controller writes the received byte back to the same RAM location and moves its pointer down by one.

The external serial clock, the active-low chip select and the serial input are brought into the system-clock domain by two-stage synchronizers. An internal transfer clock is derived from them: it follows the serial clock while the chip is selected and is held high while it is deselected. The data output driver is enabled only while the chip is selected. When the last byte has been stored, the block raises a one-cycle interrupt and drops its busy flag. The shift register keeps shifting after that for as long as the master clocks it. Two sticky flags catch protocol misuse. One is set by a chip-select change in the middle of a byte. The other is set by a serial clock edge that arrives too soon after the start command or too soon after the end of a byte.

Top module: `sio_autoxfer`

## Requirements
- R1: After synchronous reset, `busy`, `irq`, `cs_err`, `timing_err`, `ram_re` and `ram_we` are 0, and the shift register holds 0.
- R2: While the synchronized chip select is low, `sdo_oe` is 1 and serial clock edges shift the register. While it is high, `sdo_oe` is 0 and serial clock toggles leave the shift register unchanged; this is observed afterwards at `sdo`.
- R3: Bits leave and enter least significant bit first. `sdo` changes after a falling transfer-clock edge and `sdi_in` is captured on the rising edge, eight rising edges per byte.
- R4: For every byte, the RAM byte at the pointer is read and loaded into the shift register before shifting starts. After the eighth rising edge, the received byte is written back to that same address.
- R5: The pointer starts at `cfg_addr` and decreases by one after each byte, wrapping modulo 2^AW. RAM locations outside the transfer keep their contents.
- R6: After `cfg_count` bytes have completed, `irq` is high for exactly one cycle, `busy` falls in that same cycle and no further RAM access occurs.
- R7: After completion, clocking continues to shift the register: the next byte out is the last byte received. RAM is not written and `irq` does not pulse again.
- R8: A start command (`cfg_we` and `cfg_start` both 1) is ignored while `busy` is 1, and also when `cfg_count` is 0.
- R9: While busy, a change of the synchronized chip select when the bit count within the byte is not zero sets `cs_err`. The flag stays set until the next accepted start.
- R10: While busy, a falling transfer-clock edge detected fewer than START_MIN (9) cycles after an accepted start, or fewer than GAP_MIN (11) cycles after a byte completes, sets `timing_err`. The flag stays set until the next accepted start. Transfers that keep to these margins leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_start | input | 1 | Start command bit of the write |
| cfg_count | input | CW | Number of bytes to transfer |
| cfg_addr | input | AW | First RAM address |
| ram_addr | output | AW | RAM address |
| ram_re | output | 1 | RAM read request, data due next cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | Byte written to RAM |
| ram_rdata | input | 8 | Byte read from RAM |
| sclk_in | input | 1 | External serial clock |
| cs_n_in | input | 1 | Active-low chip select |
| sdi_in | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| irq | output | 1 | Completion interrupt pulse |
| busy | output | 1 | Transfer in progress |
| cs_err | output | 1 | Mid-byte chip-select change seen |
| timing_err | output | 1 | Serial clock edge came too early |

## Verification
Each pin change takes two synchronizer stages plus one edge-detect register before it is seen, and then one more cycle before `sdo` or the shift register reacts. The bench therefore holds every serial clock half-period for six system cycles and samples `sdo` at the end of the low phase. RAM effects of a byte appear within four cycles of its last rising edge, and the bench waits fifteen cycles after each byte before it compares the RAM model. Flags and the interrupt count are checked only after settled gaps of six or more cycles. The violation tests use margins well away from the 9 and 11 cycle limits, so no result depends on a single-cycle boundary.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE
    } seq_state_e;

    typedef struct packed {
        logic rise;     // transfer clock rose this cycle
        logic fall;     // transfer clock fell this cycle
        logic gate;     // deselected now and in the previous cycle
        logic cs_chg;   // synchronized select changed level
    } tclk_ev_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync
    import sio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_raw,
    input  logic     cs_n_raw,
    input  logic     sdi_raw,
    output tclk_ev_t ev,
    output logic     cs_s,
    output logic     sdi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE_LVL = 3'b011;

    logic [NSIG-1:0] pipe [STAGES];
    logic            tclk_q;
    logic            cs_q;
    logic            sclk_s;
    logic            tclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE_LVL;
            tclk_q <= 1'b1;
            cs_q   <= 1'b1;
        end else begin
            pipe[0] <= {sdi_raw, cs_n_raw, sclk_raw};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            tclk_q <= tclk;
            cs_q   <= cs_s;
        end
    end

    assign sclk_s = pipe[STAGES-1][0];
    assign cs_s   = pipe[STAGES-1][1];
    assign sdi_s  = pipe[STAGES-1][2];
    assign tclk   = cs_s | sclk_s;

    assign ev.rise   = tclk & ~tclk_q;
    assign ev.fall   = ~tclk & tclk_q;
    assign ev.gate   = cs_s & cs_q;
    assign ev.cs_chg = cs_s ^ cs_q;

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              gate,
    input  logic              sdi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic [BYTE_W-1:0] shreg,
    output logic              sdo,
    output logic              byte_done,
    output logic              mid_byte
);
    logic [BIT_CW-1:0] bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            sdo    <= 1'b1;
            bitcnt <= '0;
        end else if (load) begin
            shreg  <= load_data;
            bitcnt <= '0;
        end else begin
            if (fall) sdo <= shreg[0];
            if (rise) begin
                shreg  <= {sdi_s, shreg[BYTE_W-1:1]};
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    assign byte_done = rise && !load && (bitcnt == BIT_CW'(BYTE_W - 1));
    assign mid_byte  = (bitcnt != '0);

    AST_FROZEN_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (gate && !load) |=> $stable(shreg)) else $error("shift while deselected"); // R2

endmodule

// File: rtl/sio_seq.sv
module sio_seq
    import sio_pkg::*;
#(
    parameter int AW        = 4,
    parameter int CW        = 4,
    parameter int START_MIN = 9,
    parameter int GAP_MIN   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_start,
    input  logic [CW-1:0]     cfg_count,
    input  logic [AW-1:0]     cfg_addr,
    input  logic              byte_done,
    input  logic              fall,
    input  logic              cs_chg,
    input  logic              mid_byte,
    input  logic [BYTE_W-1:0] shreg,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              load,
    output logic              busy,
    output logic              irq,
    output logic              cs_err,
    output logic              timing_err
);
    localparam int GMAX = max_int(START_MIN, GAP_MIN);
    localparam int GW   = $clog2(GMAX + 1);

    seq_state_e    state;
    logic [AW-1:0] ptr;
    logic [CW-1:0] remain;
    logic [GW-1:0] gap_cnt;
    logic          first;
    logic          start_ok;
    int            lim;

    assign start_ok = cfg_we && cfg_start && (state == ST_IDLE) && (cfg_count != '0);
    assign lim      = first ? START_MIN : GAP_MIN;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ptr        <= '0;
            remain     <= '0;
            gap_cnt    <= '0;
            first      <= 1'b0;
            irq        <= 1'b0;
            cs_err     <= 1'b0;
            timing_err <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (int'(gap_cnt) != GMAX) gap_cnt <= gap_cnt + 1'b1;
            if (state != ST_IDLE) begin
                if (fall && int'(gap_cnt) < lim) timing_err <= 1'b1;
                if (cs_chg && mid_byte)          cs_err     <= 1'b1;
            end
            case (state)
                ST_IDLE: if (start_ok) begin
                    ptr        <= cfg_addr;
                    remain     <= cfg_count;
                    gap_cnt    <= '0;
                    first      <= 1'b1;
                    cs_err     <= 1'b0;
                    timing_err <= 1'b0;
                    state      <= ST_FETCH;
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD:  state <= ST_SHIFT;
                ST_SHIFT: if (byte_done) state <= ST_STORE;
                ST_STORE: begin
                    gap_cnt <= '0;
                    first   <= 1'b0;
                    if (remain == CW'(1)) begin
                        state <= ST_IDLE;
                        irq   <= 1'b1;
                    end else begin
                        ptr    <= ptr - 1'b1;
                        remain <= remain - 1'b1;
                        state  <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign ram_addr  = ptr;
    assign ram_re    = (state == ST_FETCH);
    assign ram_we    = (state == ST_STORE);
    assign ram_wdata = shreg;
    assign load      = (state == ST_LOAD);

    AST_RAM_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ram_re && ram_we)) else $error("read and write together"); // R4
    AST_PTR_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (ram_we && remain != CW'(1)) |=> (ptr == AW'($past(ptr) - 1'b1))) else $error("pointer step"); // R5
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq) else $error("no irq at completion"); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq too long"); // R6
    AST_NO_RAM_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(ram_we || ram_re)) else $error("RAM access while idle"); // R7

endmodule

// File: rtl/sio_autoxfer.sv
module sio_autoxfer
    import sio_pkg::*;
#(
    parameter int AW          = 4,
    parameter int CW          = 4,
    parameter int SYNC_STAGES = 2,
    parameter int START_MIN   = 9,
    parameter int GAP_MIN     = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_start,
    input  logic [CW-1:0]     cfg_count,
    input  logic [AW-1:0]     cfg_addr,
    output logic [AW-1:0]     ram_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata,
    input  logic              sclk_in,
    input  logic              cs_n_in,
    input  logic              sdi_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              irq,
    output logic              busy,
    output logic              cs_err,
    output logic              timing_err
);
    tclk_ev_t          ev;
    logic              cs_s;
    logic              sdi_s;
    logic              load;
    logic              byte_done;
    logic              mid_byte;
    logic [BYTE_W-1:0] shreg;

    sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sclk_raw (sclk_in),
        .cs_n_raw (cs_n_in),
        .sdi_raw  (sdi_in),
        .ev       (ev),
        .cs_s     (cs_s),
        .sdi_s    (sdi_s)
    );

    sio_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .rise      (ev.rise),
        .fall      (ev.fall),
        .gate      (ev.gate),
        .sdi_s     (sdi_s),
        .load      (load),
        .load_data (ram_rdata),
        .shreg     (shreg),
        .sdo       (sdo),
        .byte_done (byte_done),
        .mid_byte  (mid_byte)
    );

    sio_seq #(
        .AW(AW), .CW(CW), .START_MIN(START_MIN), .GAP_MIN(GAP_MIN)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_start  (cfg_start),
        .cfg_count  (cfg_count),
        .cfg_addr   (cfg_addr),
        .byte_done  (byte_done),
        .fall       (ev.fall),
        .cs_chg     (ev.cs_chg),
        .mid_byte   (mid_byte),
        .shreg      (shreg),
        .ram_addr   (ram_addr),
        .ram_re     (ram_re),
        .ram_we     (ram_we),
        .ram_wdata  (ram_wdata),
        .load       (load),
        .busy       (busy),
        .irq        (irq),
        .cs_err     (cs_err),
        .timing_err (timing_err)
    );

    assign sdo_oe = ~cs_s;

endmodule

// File: tb/test_sio_autoxfer.sv
module test_sio_autoxfer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_start = 1'b0;
    logic [3:0] cfg_count = '0, cfg_addr = '0;
    logic [3:0] ram_addr;
    logic       ram_re, ram_we;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata = '0;
    logic       sclk_in = 1'b1, cs_n_in = 1'b1, sdi_in = 1'b0;
    logic       sdo, sdo_oe, irq, busy, cs_err, timing_err;

    logic [7:0] mem  [16];
    logic [7:0] snap [16];
    int n_chk = 0, n_bad = 0, irq_cnt = 0;
    logic [7:0] last_rx = '0;

    always #2 clk = ~clk;

    sio_autoxfer i_sio_autoxfer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_start(cfg_start),
        .cfg_count(cfg_count), .cfg_addr(cfg_addr), .ram_addr(ram_addr),
        .ram_re(ram_re), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .sclk_in(sclk_in), .cs_n_in(cs_n_in),
        .sdi_in(sdi_in), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq), .busy(busy),
        .cs_err(cs_err), .timing_err(timing_err)
    );

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
        if (!rst && irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic bit_xfer(input logic din, output logic dout);
        sclk_in = 1'b0; sdi_in = din;
        tick(6);
        dout = sdo;
        sclk_in = 1'b1;
        tick(6);
    endtask

    task automatic byte_xfer(input logic [7:0] din, output logic [7:0] dout);
        for (int i = 0; i < 8; i++) bit_xfer(din[i], dout[i]);
    endtask

    task automatic do_start(input logic [3:0] a, input logic [3:0] n);
        cfg_we = 1'b1; cfg_start = 1'b1; cfg_addr = a; cfg_count = n;
        tick(1);
        cfg_we = 1'b0; cfg_start = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(3); rst = 1'b0; tick(1);
    endtask

    function automatic logic [7:0] rx_byte(input int k, input int n);
        return 8'(k * 53 + n * 7 + 27);
    endfunction

    task automatic run(input logic [3:0] a, input int n);
        logic [7:0] got;
        logic [3:0] ad;
        int irq0;
        for (int i = 0; i < 16; i++) snap[i] = mem[i];
        irq0 = irq_cnt;
        do_start(a, 4'(n));
        tick(12);
        chk(busy == 1'b1, "R6 busy during transfer", busy, 1);
        for (int k = 0; k < n; k++) begin
            ad = 4'(a - k);
            byte_xfer(rx_byte(k, n), got);
            chk(got == snap[ad], "R3/R4 byte shifted out", got, snap[ad]);
            tick(15);
        end
        for (int i = 0; i < 16; i++) begin
            int idx;
            idx = int'(4'(a - 4'(i)));
            if (idx < n)
                chk(mem[i] == rx_byte(idx, n), "R4/R5 received byte stored", mem[i], rx_byte(idx, n));
            else
                chk(mem[i] == snap[i], "R5 untouched location", mem[i], snap[i]);
        end
        chk(irq_cnt == irq0 + 1, "R6 single irq cycle", irq_cnt - irq0, 1);
        chk(busy == 1'b0, "R6 busy cleared", busy, 0);
        chk(timing_err == 1'b0, "R10 no timing error on legal run", timing_err, 0);
        chk(cs_err == 1'b0, "R9 no select error on legal run", cs_err, 0);
        last_rx = rx_byte(n - 1, n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        logic [7:0] got;
        logic       b;
        int         irq0;
        for (int i = 0; i < 16; i++) mem[i] = 8'(8'h3C ^ (i * 29));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(busy == 0 && irq == 0 && cs_err == 0 && timing_err == 0, "R1 reset flags", {busy, irq, cs_err, timing_err}, 0);
        chk(ram_re == 0 && ram_we == 0, "R1 reset RAM strobes", {ram_re, ram_we}, 0);
        chk(sdo_oe == 0, "R2 driver off while deselected", sdo_oe, 0);
        cs_n_in = 1'b0; tick(6);
        chk(sdo_oe == 1, "R2 driver on while selected", sdo_oe, 1);
        // R1 shift register zero: clock one byte out with no transfer
        byte_xfer(8'h00, got);
        chk(got == 8'h00, "R1 shift register cleared", got, 0);

        // sweep of byte counts and start addresses (R3 R4 R5 R6)
        for (int n = 1; n < 16; n++) run(4'((n * 5) % 16), n);

        // R7 shifting after completion, no RAM writes
        for (int i = 0; i < 16; i++) snap[i] = mem[i];
        irq0 = irq_cnt;
        byte_xfer(8'h5A, got);
        tick(15);
        chk(got == last_rx, "R7 last received byte shifts out", got, last_rx);
        for (int i = 0; i < 16; i++)
            chk(mem[i] == snap[i], "R7 RAM unchanged after completion", mem[i], snap[i]);
        chk(irq_cnt == irq0, "R7 no further irq", irq_cnt - irq0, 0);

        // R2 deselect freezes the register
        cs_n_in = 1'b1; tick(6);
        chk(sdo_oe == 0, "R2 driver off after deselect", sdo_oe, 0);
        for (int i = 0; i < 8; i++) begin
            sdi_in = 1'b1; sclk_in = 1'b0; tick(6); sclk_in = 1'b1; tick(6);
        end
        cs_n_in = 1'b0; tick(6);
        byte_xfer(8'h00, got);
        chk(got == 8'h5A, "R2 toggles ignored while deselected", got, 8'h5A);

        // R8 zero count ignored
        do_start(4'd3, 4'd0);
        tick(5);
        chk(busy == 0, "R8 zero count start ignored", busy, 0);
        // R8 start while busy ignored
        for (int i = 0; i < 16; i++) snap[i] = mem[i];
        irq0 = irq_cnt;
        do_start(4'd4, 4'd1);
        tick(3);
        do_start(4'd9, 4'd2);
        tick(8);
        byte_xfer(8'hC3, got);
        tick(15);
        chk(got == snap[4], "R8 first start kept address", got, snap[4]);
        chk(mem[4] == 8'hC3, "R8 byte stored at first address", mem[4], 8'hC3);
        chk(mem[9] == snap[9], "R8 second start left RAM alone", mem[9], snap[9]);
        chk(busy == 0 && irq_cnt == irq0 + 1, "R8 one-byte count kept", irq_cnt - irq0, 1);

        // R9 select change mid-byte
        do_start(4'd6, 4'd1);
        tick(12);
        for (int i = 0; i < 3; i++) bit_xfer(1'b0, b);
        chk(cs_err == 0, "R9 no error before change", cs_err, 0);
        cs_n_in = 1'b1; tick(6);
        chk(cs_err == 1, "R9 mid-byte select change flagged", cs_err, 1);
        do_reset();
        chk(busy == 0 && cs_err == 0 && timing_err == 0, "R1 flags cleared by reset", {busy, cs_err, timing_err}, 0);
        cs_n_in = 1'b0; tick(6);

        // R10 clock too soon after start
        do_start(4'd1, 4'd2);
        sclk_in = 1'b0; tick(6);
        chk(timing_err == 1, "R10 early first edge flagged", timing_err, 1);
        sclk_in = 1'b1; tick(6);
        do_reset();
        cs_n_in = 1'b0; tick(6);

        // R10 clock too soon after a byte
        do_start(4'd1, 4'd2);
        tick(12);
        byte_xfer(8'h11, got);
        chk(timing_err == 0, "R10 legal first byte", timing_err, 0);
        bit_xfer(1'b0, b);
        chk(timing_err == 1, "R10 short inter-byte gap flagged", timing_err, 1);
        do_reset();

        report();
    end
endmodule